// File: doc/BRIEF.md
# Interrupt Condition Status Unit

This block gathers completion and failure events from a set of load/store transaction engines and from a bank of transmit descriptor queues. It turns them into interrupt state that software can read and acknowledge over a simple register port, and it drives one combined interrupt line. Each load/store engine owns a group of eight event bits in a status register. Software acknowledges those bits through a separate write-only clear register.

The transmit queues are acknowledged differently. When the queue hardware writes a new completion pointer for a queue, that queue's interrupt becomes pending. Software reclaims the finished descriptors and then writes back the pointer value it reached. The pending state drops only when that value matches the one the hardware last wrote. A write that does not match leaves the interrupt raised, so a late hardware update is not lost.

The register port is a single-cycle write strobe with combinational read data. It has no handshake and no back-pressure. Every write is taken in the cycle its strobe is high, and read data follows the address in the same cycle.

Top module: `intr_cond_unit`

## Requirements
- R1: After reset, the status register, every queue pending bit, every stored queue pointer and the interrupt output are all zero.
- R2: A one-cycle pulse on `evt_pulse[8*u+e]` sets status bit 8*u+e, and the bit stays set until it is cleared. Here u is the engine number starting at 0, and e is the event code: 0 success, 1 error response, 2 flow-control off, 3 unsupported type or bad field, 4 timeout, 5 DMA data error, 6 retry or semaphore busy, 7 no outbound credit. The bit reads at address 0x260.
- R3: Writing the clear register at 0x268 clears every status bit whose mask bit is 1. Mask bits of 0 leave their status bits unchanged. Reading 0x268 returns 0.
- R4: When an event pulse and a clear of the same bit occur in the same cycle, the bit ends set.
- R5: A write to 0x260 loads the status register with the written value, except for bits whose event pulse is high in that cycle, which end set.
- R6: A hardware pointer write (`hw_ptr_we` with queue index `hw_ptr_q`) stores the pointer. The stored value reads at 0x300 + 4*q. If the written value differs from that queue's last acknowledged value, the queue's pending bit sets.
- R7: A register write to 0x300 + 4*q acknowledges queue q. If the written value equals the stored hardware pointer, pending clears. If it differs, pending keeps its value.
- R8: A hardware pointer write equal to the queue's last acknowledged value does not raise pending.
- R9: If a hardware pointer write and an acknowledge hit the same queue in the same cycle, pending ends set exactly when the two values differ.
- R10: `irq` is high exactly when any status bit or any queue pending bit is set. Pending bits read at 0x270, with bit q for queue q, and also appear on `txq_pend`.
- R11: Reads of unmapped addresses return 0. Writes to unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 32 | One-cycle event pulses, 8 per load/store engine |
| hw_ptr_we | input | 1 | Hardware completion pointer write strobe |
| hw_ptr_q | input | 4 | Queue index of the hardware pointer write |
| hw_ptr_data | input | 32 | Hardware completion pointer value |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| txq_pend | output | 16 | Per-queue pending interrupt |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle, the assertions check the status bits: that pulses set them, that masked clears remove them, and that an idle cycle leaves them unchanged. They also check the per-queue pending transitions for hardware writes and for matching and mismatching acknowledges. Some behaviour shows only in the bench's scenarios. This covers address decoding, clear-register read-back, unmapped accesses, and the set-wins and same-cycle queue collisions as seen at the register port. It also covers how the combined interrupt follows the mix of status and queue sources.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int EVT_PER_UNIT = 8;
  localparam int DATA_W       = 32;

  typedef enum logic [2:0] {
    EV_DONE_OK   = 3'd0,
    EV_ERR_RESP  = 3'd1,
    EV_FLOW_OFF  = 3'd2,
    EV_BAD_TYPE  = 3'd3,
    EV_TIMEOUT   = 3'd4,
    EV_DMA_ERR   = 3'd5,
    EV_RETRY     = 3'd6,
    EV_NO_CREDIT = 3'd7
  } evt_code_e;

  localparam logic [11:0] OFF_STATUS = 12'h260;
  localparam logic [11:0] OFF_CLEAR  = 12'h268;
  localparam logic [11:0] OFF_PEND   = 12'h270;
  localparam logic [11:0] OFF_QBASE  = 12'h300;
endpackage

// File: rtl/icu_evt_status.sv
module icu_evt_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] stat
);
  logic [W-1:0] base_v;
  logic [W-1:0] kill_v;
  logic [W-1:0] stat_n;

  always_comb begin
    base_v = wr_en  ? wr_data  : stat;
    kill_v = clr_en ? clr_mask : '0;
    stat_n = (base_v & ~kill_v) | evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= stat_n;
  end

  // R2: a pulsed bit is set in the following cycle
  a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((stat & $past(evt)) == $past(evt)));

  // R3: masked clear removes bits when nothing else acts
  a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !wr_en && evt == '0) |=> ((stat & $past(clr_mask)) == '0));

  // R3: with no write, clear or event the register holds
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en && !wr_en && evt == '0) |=> $stable(stat));
endmodule

// File: rtl/icu_txq_slot.sv
module icu_txq_slot #(
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_we,
  input  logic [PTR_W-1:0] hw_val,
  input  logic             sw_we,
  input  logic [PTR_W-1:0] sw_val,
  output logic [PTR_W-1:0] hw_ptr,
  output logic             pend
);
  logic [PTR_W-1:0] ack_ptr;
  logic [PTR_W-1:0] ack_n;
  logic             pend_n;

  always_comb begin
    ack_n = sw_we ? sw_val : ack_ptr;
    if (hw_we)      pend_n = (hw_val != ack_n);
    else if (sw_we) pend_n = pend && (sw_val != hw_ptr);
    else            pend_n = pend;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hw_ptr  <= '0;
      ack_ptr <= '0;
      pend    <= 1'b0;
    end else begin
      if (hw_we) hw_ptr <= hw_val;
      ack_ptr <= ack_n;
      pend    <= pend_n;
    end
  end

  // R6: a new pointer unlike the last acknowledge raises pending
  a_r6_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_we && !sw_we && hw_val != ack_ptr) |=> pend);

  // R8: a pointer equal to the last acknowledge keeps pending low
  a_r8_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_we && !sw_we && hw_val == ack_ptr) |=> !pend);

  // R7: matching acknowledge drops pending
  a_r7_ack_match: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !hw_we && sw_val == hw_ptr) |=> !pend);

  // R7: mismatching acknowledge keeps a pending interrupt
  a_r7_ack_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !hw_we && sw_val != hw_ptr && pend) |=> pend);
endmodule

// File: rtl/intr_cond_unit.sv
module intr_cond_unit
  import icu_pkg::*;
#(
  parameter int NUM_UNITS  = 4,
  parameter int NUM_QUEUES = 16,
  parameter int PTR_W      = 32,
  parameter int ADDR_W     = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_UNITS*EVT_PER_UNIT-1:0] evt_pulse,
  input  logic                          hw_ptr_we,
  input  logic [$clog2(NUM_QUEUES)-1:0] hw_ptr_q,
  input  logic [PTR_W-1:0]              hw_ptr_data,
  input  logic                          reg_we,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [DATA_W-1:0]             reg_rdata,
  output logic [NUM_QUEUES-1:0]         txq_pend,
  output logic                          irq
);
  localparam int STAT_W = NUM_UNITS * EVT_PER_UNIT;
  localparam int QIDX_W = $clog2(NUM_QUEUES);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFF_CLEAR);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_QBASE = ADDR_W'(OFF_QBASE);
  localparam logic [ADDR_W-1:0] Q_SPAN  = ADDR_W'(NUM_QUEUES * 4);

  logic [STAT_W-1:0] stat;
  logic [ADDR_W-1:0] q_off;
  logic              q_hit;
  logic [QIDX_W-1:0] q_idx;
  logic [PTR_W-1:0]  q_ptr [NUM_QUEUES];
  logic [PTR_W-1:0]  q_rd;

  assign q_off = reg_addr - A_QBASE;
  assign q_hit = (reg_addr >= A_QBASE) && (q_off < Q_SPAN) && (reg_addr[1:0] == 2'b00);
  assign q_idx = q_off[QIDX_W+1:2];

  icu_evt_status #(.W(STAT_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_pulse),
    .wr_en    (reg_we && reg_addr == A_STAT),
    .wr_data  (reg_wdata[STAT_W-1:0]),
    .clr_en   (reg_we && reg_addr == A_CLR),
    .clr_mask (reg_wdata[STAT_W-1:0]),
    .stat     (stat)
  );

  for (genvar gi = 0; gi < NUM_QUEUES; gi++) begin : g_q
    icu_txq_slot #(.PTR_W(PTR_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_we  (hw_ptr_we && hw_ptr_q == QIDX_W'(gi)),
      .hw_val (hw_ptr_data),
      .sw_we  (reg_we && q_hit && q_idx == QIDX_W'(gi)),
      .sw_val (reg_wdata[PTR_W-1:0]),
      .hw_ptr (q_ptr[gi]),
      .pend   (txq_pend[gi])
    );
  end

  always_comb begin
    q_rd = '0;
    for (int i = 0; i < NUM_QUEUES; i++)
      if (q_idx == QIDX_W'(i)) q_rd = q_ptr[i];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_STAT)      reg_rdata = DATA_W'(stat);
    else if (reg_addr == A_PEND) reg_rdata = DATA_W'(txq_pend);
    else if (q_hit)              reg_rdata = DATA_W'(q_rd);
  end

  assign irq = (|stat) || (|txq_pend);

  // R10: the interrupt cannot rise from an idle, clean state in one step
  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && evt_pulse == '0 && !hw_ptr_we && !reg_we) |=> !irq);
endmodule

// File: tb/test_intr_cond_unit.sv
module test_intr_cond_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_pulse = '0;
  logic        hw_ptr_we = 1'b0;
  logic [3:0]  hw_ptr_q = '0;
  logic [31:0] hw_ptr_data = '0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] txq_pend;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intr_cond_unit i_intr_cond_unit (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
    .hw_ptr_we(hw_ptr_we), .hw_ptr_q(hw_ptr_q), .hw_ptr_data(hw_ptr_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .txq_pend(txq_pend), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse(logic [31:0] v);
    @(negedge clk);
    evt_pulse = v;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic hw_wr(logic [3:0] q, logic [31:0] v);
    @(negedge clk);
    hw_ptr_we = 1'b1; hw_ptr_q = q; hw_ptr_data = v;
    @(negedge clk);
    hw_ptr_we = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h260, d); chk("R1 status", d, 32'h0);
    rd(12'h270, d); chk("R1 pending", d, 32'h0);
    rd(12'h30C, d); chk("R1 queue3 ptr", d, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    pulse(32'h8000_1000);
    repeat (3) @(negedge clk);
    rd(12'h260, d); chk("R2 status held", d, 32'h8000_1000);
    chk("R10 irq from status", {31'h0, irq}, 32'h1);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(12'h268, 32'h0000_1000);
    rd(12'h260, d); chk("R3 masked clear", d, 32'h8000_0000);
    wr(12'h268, 32'h0);
    rd(12'h260, d); chk("R3 zero mask no effect", d, 32'h8000_0000);
    rd(12'h268, d); chk("R3 clear reads zero", d, 32'h0);
    wr(12'h268, 32'h8000_0000);
    rd(12'h260, d); chk("R3 cleared all", d, 32'h0);
    chk("R10 irq low", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    @(negedge clk);
    evt_pulse = 32'h20; reg_addr = 12'h268; reg_wdata = 32'h20; reg_we = 1'b1;
    @(negedge clk);
    evt_pulse = '0; reg_we = 1'b0;
    rd(12'h260, d); chk("R4 set wins over clear", d, 32'h20);
    wr(12'h268, 32'hFFFF_FFFF);
  endtask

  task automatic t_direct();
    logic [31:0] d;
    wr(12'h260, 32'h0000_00A5);
    rd(12'h260, d); chk("R5 direct load", d, 32'h0000_00A5);
    @(negedge clk);
    evt_pulse = 32'h0100_0000; reg_addr = 12'h260; reg_wdata = 32'h0; reg_we = 1'b1;
    @(negedge clk);
    evt_pulse = '0; reg_we = 1'b0;
    rd(12'h260, d); chk("R5 load with event", d, 32'h0100_0000);
    wr(12'h268, 32'hFFFF_FFFF);
  endtask

  task automatic t_queue();
    logic [31:0] d;
    hw_wr(4'd3, 32'h40);
    rd(12'h30C, d); chk("R6 pointer readback", d, 32'h40);
    rd(12'h270, d); chk("R6 pending set", d, 32'h0008);
    chk("R10 irq from queue", {31'h0, irq}, 32'h1);
    wr(12'h30C, 32'h3C);
    rd(12'h270, d); chk("R7 mismatch keeps pending", d, 32'h0008);
    wr(12'h30C, 32'h40);
    rd(12'h270, d); chk("R7 match clears", d, 32'h0);
    chk("R10 irq low after ack", {31'h0, irq}, 32'h0);
    hw_wr(4'd3, 32'h40);
    rd(12'h270, d); chk("R8 equal pointer no raise", d, 32'h0);
    hw_wr(4'd15, 32'h80);
    rd(12'h270, d); chk("R6 queue15 pending", d, 32'h8000);
    rd(12'h33C, d); chk("R6 queue15 pointer", d, 32'h80);
    wr(12'h33C, 32'h80);
  endtask

  task automatic t_same();
    logic [31:0] d;
    @(negedge clk);
    hw_ptr_we = 1'b1; hw_ptr_q = 4'd5; hw_ptr_data = 32'hC0;
    reg_we = 1'b1; reg_addr = 12'h314; reg_wdata = 32'hC0;
    @(negedge clk);
    hw_ptr_we = 1'b0; reg_we = 1'b0;
    rd(12'h270, d); chk("R9 same value no pending", d, 32'h0);
    @(negedge clk);
    hw_ptr_we = 1'b1; hw_ptr_q = 4'd5; hw_ptr_data = 32'h100;
    reg_we = 1'b1; reg_addr = 12'h314; reg_wdata = 32'hC0;
    @(negedge clk);
    hw_ptr_we = 1'b0; reg_we = 1'b0;
    rd(12'h270, d); chk("R9 differing values pending", d, 32'h0020);
    wr(12'h314, 32'h100);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    pulse(32'h1);
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h100, d); chk("R11 unmapped reads zero", d, 32'h0);
    rd(12'h260, d); chk("R11 unmapped write ignored", d, 32'h1);
    wr(12'h30E, 32'h0);
    rd(12'h30C, d); chk("R11 misaligned write ignored", d, 32'h40);
    wr(12'h268, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_events();
    t_clear();
    t_collide();
    t_direct();
    t_queue();
    t_same();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule